// File: doc/BRIEF.md
# Accumulator Operate Unit

This block executes the register-only "operate" instructions of a small accumulator machine. It works on a data word (the accumulator, 12 bits by default) and a one-bit link that sits above the accumulator's most significant bit. The 9-bit operate field selects one of two groups. Every other bit of the field turns one micro-operation on or off, and one word can combine several of them.

The first group changes the accumulator and link. Its steps are clear, complement, rotate and increment, and they always run in a fixed order. The second group tests the accumulator and link and asks the program counter for one extra advance. It can also clear the accumulator after the test. The caller presents the current accumulator, the link and the field together with a one-cycle start strobe. The new accumulator, the new link and the skip request are registered and appear on the next clock edge, marked by a done strobe. Memory access and all other opcodes are handled elsewhere.

Top module: `accum_op_unit`

## Requirements
- R1: Field bit 8 selects the group: 0 is group 1 and 1 is group 2. A start strobe produces results and `done_o` high exactly one cycle later. In group 2, field bits 2..0 have no effect.
- R2: In group 1, bit 7 clears the accumulator and bit 6 clears the link.
- R3: In group 1, bit 5 complements the accumulator and bit 4 complements the link. Both act after the clears, so bits 7 and 5 together give all ones.
- R4: In group 1, bits 3..1 rotate the combined word {link, accumulator} after the complements. The codes are: 100 left by one, 010 right by one, 101 left by two, 011 right by two. The codes 000, 001, 110 and 111 leave the word unchanged.
- R5: In group 1, bit 0 adds one to {link, accumulator} after the rotate. A carry out of the accumulator toggles the link.
- R6: Group 1 steps apply in field order from bit 7 down to bit 0. So bits 7 and 0 give accumulator 1, and bits 7, 6, 4 with rotate code 101 give accumulator 2 with link 0.
- R7: In group 2, bit 6 tests for a negative accumulator (its top bit is set), bit 5 tests for a zero accumulator and bit 4 tests for link 1. The skip is the OR of the enabled tests.
- R8: In group 2, bit 3 inverts the skip. With no tests enabled, the skip is always 1 when bit 3 is set and always 0 when it is clear.
- R9: In group 2, bit 7 clears the accumulator after the tests are evaluated. The link always leaves group 2 unchanged.
- R10: Group 1 never requests a skip.
- R11: Reset clears all outputs to zero. Without a start strobe the data outputs hold their values and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to execute the field |
| op_i | input | 9 | Operate field (bit 8 selects the group) |
| ac_i | input | DATA_W | Current accumulator |
| link_i | input | 1 | Current link |
| ac_o | output | DATA_W | Resulting accumulator |
| link_o | output | 1 | Resulting link |
| skip_o | output | 1 | Request to advance the program counter by one extra word |
| done_o | output | 1 | Results valid this cycle |

## Verification
The assertions assume that `op_i`, `ac_i` and `link_i` are stable and meaningful only in a cycle where `start_i` is high. Results are compared only in the cycle after the strobe. Outside that cycle the inputs may take any value. The stimulus drives all inputs at the falling edge and strobes for single cycles or back-to-back runs. While the strobe is low it deliberately scrambles the data inputs, so the hold behaviour is exercised against real input changes.

// File: rtl/aou_pkg.sv
// Shared field positions and control types for the accumulator operate unit.
// Assumes a 9-bit operate field with the group selector in the top bit.
package aou_pkg;
    localparam int OP_W      = 9;
    localparam int B_GROUP   = 8;
    // group 1 bits
    localparam int B_CLR_AC  = 7;
    localparam int B_CLR_LNK = 6;
    localparam int B_CMP_AC  = 5;
    localparam int B_CMP_LNK = 4;
    localparam int B_ROT_HI  = 3;
    localparam int B_ROT_LO  = 1;
    localparam int B_INC     = 0;
    // group 2 bits
    localparam int B_T_NEG   = 6;
    localparam int B_T_ZERO  = 5;
    localparam int B_T_LINK  = 4;
    localparam int B_INVERT  = 3;

    localparam logic [2:0] ROT_NONE = 3'b000;
    localparam logic [2:0] ROT_L1   = 3'b100;
    localparam logic [2:0] ROT_R1   = 3'b010;
    localparam logic [2:0] ROT_L2   = 3'b101;
    localparam logic [2:0] ROT_R2   = 3'b011;

    typedef struct packed {
        logic       clr_ac;
        logic       clr_lnk;
        logic       cmp_ac;
        logic       cmp_lnk;
        logic [2:0] rot;
        logic       inc;
    } alter_ctl_t;

    typedef struct packed {
        logic clr_ac;
        logic t_neg;
        logic t_zero;
        logic t_link;
        logic invert;
    } test_ctl_t;
endpackage

// File: rtl/aou_decode.sv
// Splits the operate field into the group flag and per-group control bundles.
// Assumes the field layout in aou_pkg; pure combinational.
module aou_decode
    import aou_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output logic            is_test,
    output alter_ctl_t      alter_ctl,
    output test_ctl_t       test_ctl
);
    // Map raw field bits onto named controls.
    always_comb begin
        is_test           = op[B_GROUP];
        alter_ctl.clr_ac  = op[B_CLR_AC];
        alter_ctl.clr_lnk = op[B_CLR_LNK];
        alter_ctl.cmp_ac  = op[B_CMP_AC];
        alter_ctl.cmp_lnk = op[B_CMP_LNK];
        alter_ctl.rot     = op[B_ROT_HI:B_ROT_LO];
        alter_ctl.inc     = op[B_INC];
        test_ctl.clr_ac   = op[B_CLR_AC];
        test_ctl.t_neg    = op[B_T_NEG];
        test_ctl.t_zero   = op[B_T_ZERO];
        test_ctl.t_link   = op[B_T_LINK];
        test_ctl.invert   = op[B_INVERT];
    end
endmodule

// File: rtl/aou_alter.sv
// Group 1 datapath: clear, complement, rotate, increment on {link, acc}.
// Steps run strictly in that order; unused rotate codes do nothing.
module aou_alter
    import aou_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  alter_ctl_t        ctl,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              link_in,
    output logic [DATA_W-1:0] ac_out,
    output logic              link_out
);
    localparam int WORD_W   = DATA_W + 1;
    localparam int MAX_ROT  = 2;

    logic [DATA_W-1:0] ac_pre;
    logic              lnk_pre;
    logic              rot_left;
    int                rot_amt;
    logic [WORD_W-1:0] word;

    // Rotate the combined word by one place in the chosen direction.
    function automatic logic [WORD_W-1:0] rot_one(input logic [WORD_W-1:0] w,
                                                   input logic left);
        if (left) return {w[WORD_W-2:0], w[WORD_W-1]};
        else      return {w[0], w[WORD_W-1:1]};
    endfunction

    // Clear then complement stage.
    always_comb begin
        ac_pre  = ctl.clr_ac  ? '0   : ac_in;
        lnk_pre = ctl.clr_lnk ? 1'b0 : link_in;
        if (ctl.cmp_ac)  ac_pre  = ~ac_pre;
        if (ctl.cmp_lnk) lnk_pre = ~lnk_pre;
    end

    // Decode the rotate code into direction and distance.
    always_comb begin
        rot_left = 1'b0;
        rot_amt  = 0;
        case (ctl.rot)
            ROT_L1:  begin rot_left = 1'b1; rot_amt = 1; end
            ROT_R1:  begin rot_left = 1'b0; rot_amt = 1; end
            ROT_L2:  begin rot_left = 1'b1; rot_amt = 2; end
            ROT_R2:  begin rot_left = 1'b0; rot_amt = 2; end
            default: begin rot_left = 1'b0; rot_amt = 0; end
        endcase
    end

    // Rotate stages followed by the optional increment.
    always_comb begin
        word = {lnk_pre, ac_pre};
        for (int s = 0; s < MAX_ROT; s++) begin
            if (s < rot_amt) word = rot_one(word, rot_left);
        end
        if (ctl.inc) word = word + {{(WORD_W-1){1'b0}}, 1'b1};
        ac_out   = word[DATA_W-1:0];
        link_out = word[WORD_W-1];
    end
endmodule

// File: rtl/aou_test.sv
// Group 2 datapath: ORed condition tests with optional inversion,
// accumulator clear applied after the tests; link passes through.
module aou_test
    import aou_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  test_ctl_t         ctl,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              link_in,
    output logic [DATA_W-1:0] ac_out,
    output logic              link_out,
    output logic              skip
);
    logic any_hit;

    // Evaluate conditions on the incoming values, then clear.
    always_comb begin
        any_hit  = (ctl.t_neg  & ac_in[DATA_W-1])
                 | (ctl.t_zero & ~(|ac_in))
                 | (ctl.t_link & link_in);
        skip     = any_hit ^ ctl.invert;
        ac_out   = ctl.clr_ac ? '0 : ac_in;
        link_out = link_in;
    end
endmodule

// File: rtl/accum_op_unit.sv
// Top: decodes the operate field, runs the selected group and registers
// the results one cycle after start. Assumes inputs valid with start_i.
module accum_op_unit
    import aou_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] ac_i,
    input  logic              link_i,
    output logic [DATA_W-1:0] ac_o,
    output logic              link_o,
    output logic              skip_o,
    output logic              done_o
);
    logic              is_test;
    alter_ctl_t        alter_ctl;
    test_ctl_t         test_ctl;
    logic [DATA_W-1:0] alt_ac, tst_ac, nxt_ac;
    logic              alt_lnk, tst_lnk, nxt_lnk, tst_skip, nxt_skip;

    aou_decode u_dec (
        .op        (op_i),
        .is_test   (is_test),
        .alter_ctl (alter_ctl),
        .test_ctl  (test_ctl)
    );

    aou_alter #(.DATA_W(DATA_W)) u_alt (
        .ctl      (alter_ctl),
        .ac_in    (ac_i),
        .link_in  (link_i),
        .ac_out   (alt_ac),
        .link_out (alt_lnk)
    );

    aou_test #(.DATA_W(DATA_W)) u_tst (
        .ctl      (test_ctl),
        .ac_in    (ac_i),
        .link_in  (link_i),
        .ac_out   (tst_ac),
        .link_out (tst_lnk),
        .skip     (tst_skip)
    );

    // Select the active group's results.
    always_comb begin
        nxt_ac   = is_test ? tst_ac   : alt_ac;
        nxt_lnk  = is_test ? tst_lnk  : alt_lnk;
        nxt_skip = is_test ? tst_skip : 1'b0;
    end

    // Result registers, loaded only on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_o   <= '0;
            link_o <= 1'b0;
            skip_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                ac_o   <= nxt_ac;
                link_o <= nxt_lnk;
                skip_o <= nxt_skip;
            end
        end
    end
endmodule

// File: rtl/aou_checker.sv
// Temporal checks on the operate unit's ports; bound to every instance.
module aou_checker
    import aou_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] ac_i,
    input logic              link_i,
    input logic [DATA_W-1:0] ac_o,
    input logic              link_o,
    input logic              skip_o,
    input logic              done_o
);
    // R1
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!done_o && $stable(ac_o) && $stable(link_o) && $stable(skip_o)));
    // R10
    alter_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !op_i[B_GROUP]) |=> !skip_o);
    // R9
    test_link_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[B_GROUP]) |=> (link_o == $past(link_i)));
    // R9
    test_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[B_GROUP] && op_i[B_CLR_AC]) |=> (ac_o == '0));
    // R8
    test_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i[B_GROUP] && op_i[7:3] == 5'b00001) |=> skip_o);
    // R6
    load_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == 9'b0_1000_000_1) |=> (ac_o == DATA_W'(1)));
endmodule

bind accum_op_unit aou_checker #(.DATA_W(DATA_W)) u_aou_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .ac_i    (ac_i),
    .link_i  (link_i),
    .ac_o    (ac_o),
    .link_o  (link_o),
    .skip_o  (skip_o),
    .done_o  (done_o)
);

// File: tb/accum_op_unit_tb_top.sv
// Scoreboard bench: driver pushes predicted results, monitor compares.
module accum_op_unit_tb_top;
    localparam int W = 12;
    localparam int WORD = W + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [8:0]   op_i = '0;
    logic [W-1:0] ac_i = '0;
    logic         link_i = 1'b0;
    logic [W-1:0] ac_o;
    logic         link_o, skip_o, done_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [W-1:0] ac;
        logic         lnk;
        logic         skp;
        string        req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    accum_op_unit #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .ac_i(ac_i), .link_i(link_i), .ac_o(ac_o), .link_o(link_o),
        .skip_o(skip_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] g1(input bit cla, cll, cma, cml,
                                      input logic [2:0] rot, input bit iac);
        return {1'b0, cla, cll, cma, cml, rot, iac};
    endfunction

    function automatic logic [8:0] g2(input bit cla, neg, zer, lnk, rev);
        return {1'b1, cla, neg, zer, lnk, rev, 3'b000};
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t predict(input logic [8:0] op, input logic [W-1:0] a,
                                     input logic l, input string req);
        exp_t e;
        logic [WORD-1:0] v;
        logic [WORD-1:0] mask;
        int n;
        bit left;
        mask = '1;
        e.req = req;
        if (!op[8]) begin
            if (op[7]) a = '0;
            if (op[6]) l = 1'b0;
            if (op[5]) a = ~a;
            if (op[4]) l = ~l;
            v = {l, a};
            n = 0; left = 0;
            if (op[3:1] == 3'b100) begin n = 1; left = 1; end
            if (op[3:1] == 3'b010) begin n = 1; left = 0; end
            if (op[3:1] == 3'b101) begin n = 2; left = 1; end
            if (op[3:1] == 3'b011) begin n = 2; left = 0; end
            if (n > 0) begin
                if (left) v = ((v << n) | (v >> (WORD - n))) & mask;
                else      v = ((v >> n) | (v << (WORD - n))) & mask;
            end
            if (op[0]) v = v + 1;
            e.ac = v[W-1:0]; e.lnk = v[W]; e.skp = 1'b0;
        end else begin
            bit hit;
            hit = (op[6] && a[W-1]) || (op[5] && a == 0) || (op[4] && l);
            e.skp = op[3] ? !hit : hit;
            e.ac = op[7] ? '0 : a;
            e.lnk = l;
        end
        return e;
    endfunction

    task automatic issue(input logic [8:0] op, input logic [W-1:0] a,
                         input logic l, input string req);
        @(negedge clk);
        sb.push_back(predict(op, a, l, req));
        start_i = 1'b1; op_i = op; ac_i = a; link_i = l;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            op_i = 9'($urandom); ac_i = W'($urandom); link_i = 1'($urandom);
        end
    endtask

    // Monitor: compare each completed result with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "unexpected done", 16'(done_o), 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(ac_o == e.ac, e.req, "ac", 16'(ac_o), 16'(e.ac));
                check(link_o == e.lnk, e.req, "link", 16'(link_o), 16'(e.lnk));
                check(skip_o == e.skp, e.req, "skip", 16'(skip_o), 16'(e.skp));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 16'd0, 16'd1);
        finish_run();
    end

    initial begin
        logic [W-1:0] snap_ac;
        logic snap_l, snap_s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(ac_o == 0, "R11", "reset ac", 16'(ac_o), 16'd0);
        check(link_o == 0, "R11", "reset link", 16'(link_o), 16'd0);
        check(skip_o == 0, "R11", "reset skip", 16'(skip_o), 16'd0);
        check(done_o == 0, "R11", "reset done", 16'(done_o), 16'd0);

        // R2 clears
        issue(g1(1,0,0,0,3'b000,0), 12'h5A5, 1'b1, "R2");
        issue(g1(0,1,0,0,3'b000,0), 12'h5A5, 1'b1, "R2");
        // R3 complements after clear
        issue(g1(1,0,1,0,3'b000,0), 12'h123, 1'b0, "R3");
        issue(g1(0,0,0,1,3'b000,0), 12'h123, 1'b0, "R3");
        issue(g1(0,1,0,1,3'b000,0), 12'h000, 1'b0, "R3");
        // R4 rotates
        issue(g1(0,0,0,0,3'b100,0), 12'h800, 1'b0, "R4");
        issue(g1(0,0,0,0,3'b010,0), 12'h001, 1'b0, "R4");
        issue(g1(0,0,0,0,3'b101,0), 12'hC00, 1'b1, "R4");
        issue(g1(0,0,0,0,3'b011,0), 12'h001, 1'b0, "R4");
        issue(g1(0,0,0,0,3'b110,0), 12'h9A3, 1'b1, "R4");
        issue(g1(0,0,0,0,3'b001,0), 12'h9A3, 1'b0, "R4");
        issue(g1(0,0,0,0,3'b111,0), 12'h9A3, 1'b1, "R4");
        // R5 increment and carry into the link
        issue(g1(0,0,0,0,3'b000,1), 12'hFFF, 1'b0, "R5");
        issue(g1(0,0,0,0,3'b000,1), 12'hFFF, 1'b1, "R5");
        issue(g1(0,0,0,0,3'b000,1), 12'h07F, 1'b1, "R5");
        // R6 ordering
        issue(g1(1,0,0,0,3'b000,1), 12'hABC, 1'b1, "R6");
        issue(g1(1,1,0,1,3'b101,0), 12'h777, 1'b0, "R6");
        issue(g1(0,0,1,0,3'b100,1), 12'h7FF, 1'b0, "R6");
        // R10 group 1 never skips
        issue(g1(1,1,1,1,3'b011,1), 12'h000, 1'b1, "R10");
        // R7 ORed tests
        issue(g2(0,1,0,0,0), 12'h800, 1'b0, "R7");
        issue(g2(0,0,1,0,0), 12'h003, 1'b0, "R7");
        issue(g2(0,0,0,1,0), 12'h003, 1'b1, "R7");
        issue(g2(0,1,1,0,0), 12'h000, 1'b0, "R7");
        // R8 inverted sense
        issue(g2(0,1,1,0,1), 12'h005, 1'b0, "R8");
        issue(g2(0,1,1,0,1), 12'h000, 1'b0, "R8");
        issue(g2(0,1,1,0,1), 12'h800, 1'b0, "R8");
        issue(g2(0,0,0,0,1), 12'h800, 1'b1, "R8");
        issue(g2(0,0,0,0,0), 12'h000, 1'b1, "R8");
        // R9 clear after test, link unchanged
        issue(g2(1,0,1,0,0), 12'h000, 1'b1, "R9");
        issue(g2(1,0,1,0,0), 12'h007, 1'b0, "R9");
        issue(g2(1,1,0,0,1), 12'hF00, 1'b1, "R9");
        // R1 low bits ignored in group 2
        issue(g2(0,0,0,1,0) | 9'h007, 12'h444, 1'b0, "R1");
        idle(2);

        // R11 hold while idle
        snap_ac = ac_o; snap_l = link_o; snap_s = skip_o;
        idle(3);
        check(ac_o == snap_ac, "R11", "hold ac", 16'(ac_o), 16'(snap_ac));
        check(link_o == snap_l, "R11", "hold link", 16'(link_o), 16'(snap_l));
        check(skip_o == snap_s, "R11", "hold skip", 16'(skip_o), 16'(snap_s));
        check(done_o == 0, "R11", "idle done", 16'(done_o), 16'd0);

        // R1 mixed random traffic, back-to-back and gapped
        for (int i = 0; i < 400; i++) begin
            issue(9'($urandom), W'($urandom), 1'($urandom), "R1");
            if ((i % 7) == 3) idle(1);
        end
        idle(3);
        check(sb.size() == 0, "R1", "pending results", 16'(sb.size()), 16'd0);
        finish_run();
    end
endmodule